// File: doc/BRIEF.md
# Temperature and Identity Scan Sequencer for Sixteen 1-Wire Sensors

This block sits on top of a byte-level 1-Wire engine. It drives that engine through a request/acknowledge interface. It keeps an identity code and a temperature reading for each of sixteen sensor lines. Lines 0 to 14 serve the attached frontend cards, and line 15 serves the backplane module.

The sensors convert only when the host asks. A host readout request does two things. First, it gathers what the sensors measured at the previous request. Second, it starts a fresh conversion on every line at once. Because of this, a readout always delivers the previous conversion, and the first readout after reset delivers nothing valid.

Stored results are presented on a combinational read port indexed by slot. While a scan is running, the block ignores further requests.

Top module: `ow_scan_top`

## Requirements
- R1: Bus activity (`eng_req` high) and temperature conversions only ever follow an accepted host request. An idle block never raises `eng_req` by itself, however long it waits.
- R2: A request accepted while idle makes `host_busy` high at the next clock. `host_busy` falls in the cycle after the engine acknowledges the broadcast convert byte 0x44.
- R3: `host_req` is ignored while `host_busy` is high, including in the cycle where the final convert byte is acknowledged. Such a request adds no transfer and no conversion.
- R4: The first readout after reset issues exactly three transfers, all broadcast (`eng_bcast`=1): bus reset, write 0xCC, write 0x44. It issues no reads and leaves every slot's valid flag at 0.
- R5: Every later readout first visits slots 0 to 15 in ascending order, each on its own line (`eng_slot`). Per slot the transfers are: reset, write 0x33, eight reads, reset, write 0xCC, write 0xBE, two reads. The broadcast reset/0xCC/0x44 follows, for 243 transfers in all.
- R6: Received bytes are assembled least significant first. The first identity byte lands in `rd_id[7:0]`, and the first scratchpad byte lands in `rd_temp[7:0]`.
- R7: The temperature a readout stores for a slot is the one produced by the conversion that the previous readout started.
- R8: Valid flags are 0 after reset and are all cleared when a request is accepted. A slot's flag is set when its last temperature byte is acknowledged.
- R9: Engine encoding is `eng_op` 0 = bus reset, 1 = write `eng_wdata`, 2 = read into `eng_rdata`. `eng_req` stays high with op, data, slot and broadcast unchanged until `eng_ack`.
- R10: `rd_id`, `rd_temp` and `rd_valid` show the slot selected by `rd_slot` in the same cycle, without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Readout request pulse |
| host_busy | output | 1 | Scan in progress |
| rd_slot | input | 4 | Slot selected on the read port |
| rd_id | output | 64 | Identity code of the selected slot |
| rd_temp | output | 16 | Temperature word of the selected slot |
| rd_valid | output | 1 | Selected slot holds a valid result |
| eng_req | output | 1 | Transfer request to the byte engine |
| eng_op | output | 2 | Transfer kind: 0 reset, 1 write, 2 read |
| eng_wdata | output | 8 | Byte to write |
| eng_slot | output | 4 | Sensor line for a single-line transfer |
| eng_bcast | output | 1 | Transfer goes to all lines at once |
| eng_ack | input | 1 | Engine finished the current transfer |
| eng_rdata | input | 8 | Byte read, valid with `eng_ack` |

## Verification
Two functions can fall in the same cycle. One is the acknowledgement of the final convert byte, which ends the scan. The other is a new host request, which would start one. The bench provokes this by having its engine model raise `host_req` in exactly the cycle it acknowledges 0x44. It judges the outcome by three facts: `host_busy` falls and stays low, no further transfer appears, and the conversion count rises by only one. A second collision, a request in the middle of a scan, is judged the same way by the transfer total of 243.

// File: rtl/ow_scan_pkg.sv
package ow_scan_pkg;

   typedef enum logic [1:0] {
      OW_RESET = 2'd0,
      OW_WRITE = 2'd1,
      OW_READ  = 2'd2
   } ow_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE    = 2'd0,
      SQ_COLLECT = 2'd1,
      SQ_CONVERT = 2'd2
   } sq_state_e;

   localparam logic [7:0] CMD_READ_ROM = 8'h33;
   localparam logic [7:0] CMD_SKIP_ROM = 8'hCC;
   localparam logic [7:0] CMD_READ_PAD = 8'hBE;
   localparam logic [7:0] CMD_CONVERT  = 8'h44;

   // transfers per slot: reset, read-rom cmd, id reads, reset, skip, read-pad cmd, temp reads
   function automatic int slot_steps(input int id_bytes, input int temp_bytes);
      return id_bytes + temp_bytes + 5;
   endfunction

endpackage

// File: rtl/ow_scan_step_rom.sv
module ow_scan_step_rom
   import ow_scan_pkg::*;
#(
   parameter int ID_BYTES   = 8,
   parameter int TEMP_BYTES = 2,
   parameter int STEP_W     = 4,
   parameter int BYTE_W     = 4
) (
   input  logic              collect,
   input  logic [STEP_W-1:0] step,
   output ow_op_e            op,
   output logic [7:0]        wdata,
   output logic              is_read,
   output logic [BYTE_W-1:0] byte_idx,
   output logic              last_step
);

   localparam int SLOT_STEPS = slot_steps(ID_BYTES, TEMP_BYTES);
   localparam int CONV_LAST  = 2;

   int k;

   always_comb begin
      k         = int'(step);
      op        = OW_RESET;
      wdata     = 8'h00;
      is_read   = 1'b0;
      byte_idx  = '0;
      last_step = 1'b0;
      if (collect) begin
         last_step = (k == SLOT_STEPS - 1);
         if (k == 0) begin
            op = OW_RESET;
         end else if (k == 1) begin
            op    = OW_WRITE;
            wdata = CMD_READ_ROM;
         end else if (k < ID_BYTES + 2) begin
            op       = OW_READ;
            is_read  = 1'b1;
            byte_idx = BYTE_W'(k - 2);
         end else if (k == ID_BYTES + 2) begin
            op = OW_RESET;
         end else if (k == ID_BYTES + 3) begin
            op    = OW_WRITE;
            wdata = CMD_SKIP_ROM;
         end else if (k == ID_BYTES + 4) begin
            op    = OW_WRITE;
            wdata = CMD_READ_PAD;
         end else begin
            op       = OW_READ;
            is_read  = 1'b1;
            byte_idx = BYTE_W'(k - 5);
         end
      end else begin
         last_step = (k == CONV_LAST);
         if (k == 1) begin
            op    = OW_WRITE;
            wdata = CMD_SKIP_ROM;
         end else if (k == 2) begin
            op    = OW_WRITE;
            wdata = CMD_CONVERT;
         end
      end
   end

endmodule

// File: rtl/ow_scan_seq.sv
module ow_scan_seq
   import ow_scan_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int STEP_W    = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         host_req,
   input  logic                         eng_ack,
   input  logic                         last_step,
   output logic                         busy,
   output logic                         collect,
   output logic [$clog2(NUM_SLOTS)-1:0] slot,
   output logic [STEP_W-1:0]            step,
   output logic                         clr_valid
);

   localparam int SLOT_W = $clog2(NUM_SLOTS);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

   sq_state_e state_q;
   logic      conv_pending_q;

   assign busy      = (state_q != SQ_IDLE);
   assign collect   = (state_q == SQ_COLLECT);
   assign clr_valid = host_req && (state_q == SQ_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q        <= SQ_IDLE;
         conv_pending_q <= 1'b0;
         slot           <= '0;
         step           <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (host_req) begin
                  slot    <= '0;
                  step    <= '0;
                  state_q <= conv_pending_q ? SQ_COLLECT : SQ_CONVERT;
               end
            end
            SQ_COLLECT: begin
               if (eng_ack) begin
                  if (last_step) begin
                     step <= '0;
                     if (slot == SLOT_LAST) begin
                        slot    <= '0;
                        state_q <= SQ_CONVERT;
                     end else begin
                        slot <= slot + 1'b1;
                     end
                  end else begin
                     step <= step + 1'b1;
                  end
               end
            end
            SQ_CONVERT: begin
               if (eng_ack) begin
                  if (last_step) begin
                     step           <= '0;
                     conv_pending_q <= 1'b1;
                     state_q        <= SQ_IDLE;
                  end else begin
                     step <= step + 1'b1;
                  end
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !eng_ack |=> busy && $stable(slot) && $stable(step) && $stable(collect));

   // R1
   start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(host_req));

   // R3
   late_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !collect && eng_ack && last_step && host_req |=> !busy);

endmodule

// File: rtl/ow_scan_results.sv
module ow_scan_results #(
   parameter int NUM_SLOTS  = 16,
   parameter int ID_BYTES   = 8,
   parameter int TEMP_BYTES = 2,
   parameter int BYTE_W     = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr_valid,
   input  logic                         byte_we,
   input  logic [$clog2(NUM_SLOTS)-1:0] byte_slot,
   input  logic [BYTE_W-1:0]            byte_idx,
   input  logic [7:0]                   byte_data,
   input  logic                         set_valid,
   input  logic [$clog2(NUM_SLOTS)-1:0] rd_slot,
   output logic [8*ID_BYTES-1:0]        rd_id,
   output logic [8*TEMP_BYTES-1:0]      rd_temp,
   output logic                         rd_valid
);

   localparam int SLOT_W = $clog2(NUM_SLOTS);
   localparam int ID_W   = 8 * ID_BYTES;
   localparam int TEMP_W = 8 * TEMP_BYTES;

   logic [ID_W-1:0]   id_all    [NUM_SLOTS];
   logic [TEMP_W-1:0] temp_all  [NUM_SLOTS];
   logic              valid_all [NUM_SLOTS];

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic [ID_W-1:0]   id_r;
      logic [TEMP_W-1:0] temp_r;
      logic              valid_r;
      logic              hit;

      assign hit = byte_we && (byte_slot == SLOT_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            id_r    <= '0;
            temp_r  <= '0;
            valid_r <= 1'b0;
         end else begin
            for (int b = 0; b < ID_BYTES; b++) begin
               if (hit && byte_idx == BYTE_W'(b)) id_r[8*b +: 8] <= byte_data;
            end
            for (int t = 0; t < TEMP_BYTES; t++) begin
               if (hit && byte_idx == BYTE_W'(ID_BYTES + t)) temp_r[8*t +: 8] <= byte_data;
            end
            if (clr_valid) valid_r <= 1'b0;
            else if (set_valid && byte_slot == SLOT_W'(g)) valid_r <= 1'b1;
         end
      end

      assign id_all[g]    = id_r;
      assign temp_all[g]  = temp_r;
      assign valid_all[g] = valid_r;

      // R8
      valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(valid_r) |-> $past(set_valid && byte_slot == SLOT_W'(g)));

      // R8
      valid_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         clr_valid |=> !valid_r);
   end

   assign rd_id    = id_all[rd_slot];
   assign rd_temp  = temp_all[rd_slot];
   assign rd_valid = valid_all[rd_slot];

endmodule

// File: rtl/ow_scan_top.sv
module ow_scan_top
   import ow_scan_pkg::*;
#(
   parameter int NUM_SLOTS  = 16,
   parameter int ID_BYTES   = 8,
   parameter int TEMP_BYTES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         host_req,
   output logic                         host_busy,
   input  logic [$clog2(NUM_SLOTS)-1:0] rd_slot,
   output logic [8*ID_BYTES-1:0]        rd_id,
   output logic [8*TEMP_BYTES-1:0]      rd_temp,
   output logic                         rd_valid,
   output logic                         eng_req,
   output logic [1:0]                   eng_op,
   output logic [7:0]                   eng_wdata,
   output logic [$clog2(NUM_SLOTS)-1:0] eng_slot,
   output logic                         eng_bcast,
   input  logic                         eng_ack,
   input  logic [7:0]                   eng_rdata
);

   localparam int SLOT_W     = $clog2(NUM_SLOTS);
   localparam int SLOT_STEPS = slot_steps(ID_BYTES, TEMP_BYTES);
   localparam int STEP_W     = $clog2(SLOT_STEPS);
   localparam int BYTE_W     = $clog2(ID_BYTES + TEMP_BYTES);

   if (NUM_SLOTS < 2 || (NUM_SLOTS & (NUM_SLOTS - 1)) != 0) begin : g_bad_slots
      $error("NUM_SLOTS must be a power of two of at least 2");
   end
   if (ID_BYTES < 1 || TEMP_BYTES < 1) begin : g_bad_bytes
      $error("ID_BYTES and TEMP_BYTES must be at least 1");
   end

   logic              busy;
   logic              collect;
   logic [SLOT_W-1:0] slot;
   logic [STEP_W-1:0] step;
   logic              clr_valid;
   ow_op_e            op;
   logic [7:0]        wdata;
   logic              is_read;
   logic [BYTE_W-1:0] byte_idx;
   logic              last_step;
   logic              byte_we;
   logic              set_valid;

   ow_scan_seq #(
      .NUM_SLOTS (NUM_SLOTS),
      .STEP_W    (STEP_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_req  (host_req),
      .eng_ack   (eng_ack),
      .last_step (last_step),
      .busy      (busy),
      .collect   (collect),
      .slot      (slot),
      .step      (step),
      .clr_valid (clr_valid)
   );

   ow_scan_step_rom #(
      .ID_BYTES   (ID_BYTES),
      .TEMP_BYTES (TEMP_BYTES),
      .STEP_W     (STEP_W),
      .BYTE_W     (BYTE_W)
   ) u_rom (
      .collect   (collect),
      .step      (step),
      .op        (op),
      .wdata     (wdata),
      .is_read   (is_read),
      .byte_idx  (byte_idx),
      .last_step (last_step)
   );

   assign byte_we   = busy && eng_ack && is_read;
   assign set_valid = busy && eng_ack && collect && last_step;

   ow_scan_results #(
      .NUM_SLOTS  (NUM_SLOTS),
      .ID_BYTES   (ID_BYTES),
      .TEMP_BYTES (TEMP_BYTES),
      .BYTE_W     (BYTE_W)
   ) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_valid (clr_valid),
      .byte_we   (byte_we),
      .byte_slot (slot),
      .byte_idx  (byte_idx),
      .byte_data (eng_rdata),
      .set_valid (set_valid),
      .rd_slot   (rd_slot),
      .rd_id     (rd_id),
      .rd_temp   (rd_temp),
      .rd_valid  (rd_valid)
   );

   assign host_busy = busy;
   assign eng_req   = busy;
   assign eng_op    = op;
   assign eng_wdata = wdata;
   assign eng_slot  = collect ? slot : '0;
   assign eng_bcast = busy && !collect;

   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req && eng_ack && eng_bcast && eng_op == 2'd1 && eng_wdata == CMD_CONVERT
      |=> !host_busy);

endmodule

// File: tb/ow_scan_top_test.sv
`timescale 1ns/1ps
module ow_scan_top_test;

   localparam int NS  = 16;
   localparam int IDB = 8;
   localparam int TB  = 2;
   localparam int FULL_XFERS = NS * (IDB + TB + 5) + 3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_t;
   logic        req_inj;
   logic        host_req;
   logic        host_busy;
   logic [3:0]  rd_slot;
   logic [63:0] rd_id;
   logic [15:0] rd_temp;
   logic        rd_valid;
   logic        eng_req;
   logic [1:0]  eng_op;
   logic [7:0]  eng_wdata;
   logic [3:0]  eng_slot;
   logic        eng_bcast;
   logic        eng_ack;
   logic [7:0]  eng_rdata;

   always #2.5 clk = ~clk;
   assign host_req = req_t | req_inj;

   ow_scan_top uut (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_busy(host_busy),
      .rd_slot(rd_slot), .rd_id(rd_id), .rd_temp(rd_temp), .rd_valid(rd_valid),
      .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
      .eng_slot(eng_slot), .eng_bcast(eng_bcast),
      .eng_ack(eng_ack), .eng_rdata(eng_rdata)
   );

   int errors = 0;
   int checks = 0;
   int lat = 0;
   int conv_n = 0;
   int xfers = 0;
   int reads = 0;
   int exp_slot = 0;
   bit inject_last = 1'b0;
   logic [15:0] pad [NS];

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
      end
   endtask

   function automatic logic [63:0] id_of(input int s);
      logic [63:0] r;
      for (int b = 0; b < IDB; b++) r[8*b +: 8] = 8'(s * 16 + b * 3 + 17);
      return r;
   endfunction

   function automatic logic [15:0] temp_of(input int s, input int n);
      return {8'(n * 16 + s + 32), 8'(s * 5 + n * 3 + 1)};
   endfunction

   // byte engine model
   initial begin : engine
      logic [7:0] mode [NS];
      int         rcnt [NS];
      logic [1:0] op0;
      logic [7:0] wd0;
      logic [3:0] sl0;
      bit         conv_done;
      bit         inj_on;
      int         s;
      eng_ack   = 1'b0;
      eng_rdata = 8'h00;
      req_inj   = 1'b0;
      conv_done = 1'b0;
      inj_on    = 1'b0;
      for (int i = 0; i < NS; i++) begin
         pad[i] = 16'h0550; mode[i] = 8'h00; rcnt[i] = 0;
      end
      forever begin
         @(negedge clk);
         eng_ack = 1'b0;
         if (inj_on) begin req_inj = 1'b0; inj_on = 1'b0; end
         if (conv_done) begin
            chk(host_busy == 1'b0, "R2 busy low after convert ack", 64'(host_busy), 64'd0);
            conv_done = 1'b0;
         end
         if (eng_req === 1'b1) begin
            op0 = eng_op; wd0 = eng_wdata; sl0 = eng_slot;
            repeat (lat) @(negedge clk);
            if (lat > 0)
               chk(eng_op == op0 && eng_wdata == wd0 && eng_slot == sl0 && eng_req,
                   "R9 request held", {eng_op, eng_wdata, eng_slot}, {op0, wd0, sl0});
            s = int'(eng_slot);
            xfers++;
            case (eng_op)
               2'd0: rcnt[s] = 0;
               2'd1: begin
                  mode[s] = eng_wdata;
                  rcnt[s] = 0;
                  if (eng_bcast && eng_wdata == 8'h44) begin
                     conv_n++;
                     for (int i = 0; i < NS; i++) pad[i] = temp_of(i, conv_n);
                     chk(host_busy == 1'b1, "R2 busy at convert ack", 64'(host_busy), 64'd1);
                     conv_done = 1'b1;
                     if (inject_last) begin req_inj = 1'b1; inj_on = 1'b1; end
                  end
               end
               default: begin
                  reads++;
                  if (mode[s] == 8'h33) begin
                     if (rcnt[s] == 0) begin
                        chk(s == exp_slot && !eng_bcast, "R5 slot order", 64'(s), 64'(exp_slot));
                        exp_slot++;
                     end
                     eng_rdata = id_of(s)[8*rcnt[s] +: 8];
                  end else begin
                     eng_rdata = pad[s][8*rcnt[s] +: 8];
                  end
                  rcnt[s]++;
               end
            endcase
            eng_ack = 1'b1;
         end
      end
   end

   task automatic readout(input int spam_at);
      int guard;
      exp_slot = 0;
      @(negedge clk); req_t = 1'b1;
      @(negedge clk); req_t = 1'b0;
      chk(host_busy == 1'b1, "R2 busy after request", 64'(host_busy), 64'd1);
      for (int s = 0; s < NS; s += 5) begin
         rd_slot = 4'(s); #0.1;
         chk(rd_valid == 1'b0, "R8 valid cleared on accept", 64'(rd_valid), 64'd0);
      end
      guard = 0;
      while (host_busy) begin
         @(negedge clk);
         guard++;
         if (guard == spam_at) begin
            req_t = 1'b1; @(negedge clk); req_t = 1'b0;
         end
      end
   endtask

   task automatic check_table(input bit exp_valid, input int n, input string rq);
      for (int s = 0; s < NS; s++) begin
         rd_slot = 4'(s); #0.1;
         chk(rd_valid == exp_valid, {rq, " R8 valid"}, 64'(rd_valid), 64'(exp_valid));
         if (exp_valid) begin
            chk(rd_id == id_of(s), {rq, " R6 id"}, rd_id, id_of(s));
            chk(rd_temp == temp_of(s, n), {rq, " R7 temp"}, 64'(rd_temp), 64'(temp_of(s, n)));
         end
      end
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin : main
      int x0, r0, c0;
      rst_n = 1'b0; req_t = 1'b0; rd_slot = 4'd0;
      repeat (5) @(negedge clk);
      chk(host_busy == 1'b0 && eng_req == 1'b0, "R2 idle in reset", {host_busy, eng_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_table(1'b0, 0, "reset");

      // first readout: R4
      lat = 0; x0 = xfers; r0 = reads;
      readout(0);
      chk(xfers - x0 == 3, "R4 transfer count", 64'(xfers - x0), 64'd3);
      chk(reads == r0, "R4 no reads", 64'(reads - r0), 64'd0);
      chk(conv_n == 1, "R4 one conversion", 64'(conv_n), 64'd1);
      check_table(1'b0, 0, "first");

      // R1: idle, no autonomous activity
      x0 = xfers;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (eng_req) begin
            chk(1'b0, "R1 eng_req while idle", 64'd1, 64'd0);
            break;
         end
      end
      chk(xfers == x0 && conv_n == 1, "R1 no autonomous conversion", 64'(conv_n), 64'd1);

      // second readout with a request in mid-scan: R3, R5
      lat = 1; x0 = xfers; r0 = reads;
      readout(40);
      chk(xfers - x0 == FULL_XFERS, "R3 R5 transfer count", 64'(xfers - x0), 64'(FULL_XFERS));
      chk(reads - r0 == NS * (IDB + TB), "R5 read count", 64'(reads - r0), 64'(NS * (IDB + TB)));
      chk(conv_n == 2, "R3 conversion count", 64'(conv_n), 64'd2);
      check_table(1'b1, 1, "second");

      // third readout, request collides with final ack: R3
      lat = 2; inject_last = 1'b1; x0 = xfers;
      readout(0);
      inject_last = 1'b0;
      repeat (20) @(negedge clk);
      chk(host_busy == 1'b0, "R3 late request ignored", 64'(host_busy), 64'd0);
      chk(xfers - x0 == FULL_XFERS && conv_n == 3, "R3 no extra scan", 64'(xfers - x0), 64'(FULL_XFERS));
      check_table(1'b1, 2, "third");

      // fourth readout, longer latency
      lat = 3;
      readout(0);
      check_table(1'b1, 3, "fourth");
      rd_slot = 4'd15; #0.1;
      chk(rd_temp == temp_of(15, 3), "R10 backplane slot", 64'(rd_temp), 64'(temp_of(15, 3)));
      rd_slot = 4'd3; #0.1;
      chk(rd_id == id_of(3), "R10 combinational select", rd_id, id_of(3));

      summary();
   end

endmodule